// File: doc/BRIEF.md
# Wakeup Interrupt Pin Monitor

This block sits in the always-on part of a chip. While the main processor is powered down, it watches a parameterised set of wakeup pins and raises one wakeup interrupt when a pin that software has enabled sees the event chosen for it. Each pin can be armed for a rising edge, a falling edge, or both. A pin with neither edge armed is level sensed, and a polarity bit sets the active level. Every detected event sets a sticky status bit, whether or not the pin is enabled.

Software reaches the block through a simple word-addressed register port with a combinational read path. Two plain timer words come first. They are followed by five banks of per-pin words: enable, falling-edge, rising-edge, polarity and status. Before entering sleep, software clears the status bank. After waking, it reads the status bank to find out which pins fired. The pins are asynchronous and are resynchronised inside the block. The asynchronous reset is released synchronously.

Top module: `wake_pin_monitor`

## Requirements
- R1: With stride S = ceil(PIN_COUNT/32), the two timer words sit at byte addresses 0x00 and 0x04. Word i of bank k sits at byte address (k*S + i + 2)*4, with k = 0 enable, 1 falling-edge, 2 rising-edge, 3 polarity and 4 status. Pin p occupies word p/32, bit p%32. Address bits [1:0] are ignored.
- R2: While rst_n is low, every register word reads zero and wake_irq_o is 0. After release, the timer, enable, edge and polarity words still read zero.
- R3: The timer, enable, falling-edge, rising-edge and polarity words read back the last value written to them.
- R4: A pin whose rising bit is set latches status on a 0-to-1 change of its synchronised input. A pin whose falling bit is set latches status on a 1-to-0 change. The two bits act independently, so a pin with both set latches on either change.
- R5: A pin with both edge bits clear latches status in every cycle in which its synchronised input equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R6: An event sets the status bit even when the pin is disabled. A status bit whose enable bit is 0 never raises wake_irq_o.
- R7: wake_irq_o is a register loaded with the OR over all pins of (status AND enable). It stays high until the contributing bits are cleared or disabled, and it falls one clock after that register write.
- R8: A status write clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as the clear wins, so the bit stays set.
- R9: A pin change applied between clock edges appears in the status read after the third following rising edge, and on wake_irq_o after the fourth.
- R10: Reads of word addresses beyond the last status word return zero. Writes to those addresses change no register.
- R11: A status bit stays set after the condition that set it goes away, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pins_i | input | PIN_COUNT | Asynchronous wakeup pin inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| wake_irq_o | output | 1 | Combined wakeup interrupt |

## Verification
Stale status state shows up in the status read three edges after a pin moves, and in wake_irq_o one edge later. Each randomized trial therefore clears status, applies one pin change and reads both status words once the pipeline has settled. A wrong enable or clear path shows up as wake_irq_o staying high, or failing to rise, exactly one clock after the write. Directed cases check that timing cycle by cycle. A decode fault shows up as data appearing in a neighbouring word or at an out-of-range address, which the read-back sweeps look for.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int WORD_W    = 32;
  localparam int TIMER_CNT = 2;
  localparam int BANK_CNT  = 5;

  typedef enum int {
    BK_ENABLE = 0,
    BK_FALL   = 1,
    BK_RISE   = 2,
    BK_POL    = 3,
    BK_STATUS = 4
  } bank_e;

  function automatic int stride_of(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int word_index(input int bank, input int sub, input int stride);
    return TIMER_CNT + bank * stride + sub;
  endfunction
endpackage

// File: rtl/wpm_sync.sv
module wpm_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/wpm_detect.sv
module wpm_detect #(
  parameter int PIN_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] sync_i,
  input  logic [PIN_COUNT-1:0] rise_i,
  input  logic [PIN_COUNT-1:0] fall_i,
  input  logic [PIN_COUNT-1:0] pol_i,
  output logic [PIN_COUNT-1:0] event_o
);
  logic [PIN_COUNT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= sync_i;
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic armed;
    logic went_up;
    logic went_down;
    logic level_hit;
    assign armed     = rise_i[p] | fall_i[p];
    assign went_up   = sync_i[p] & ~prev_q[p];
    assign went_down = ~sync_i[p] & prev_q[p];
    assign level_hit = (sync_i[p] == pol_i[p]);
    assign event_o[p] = armed ? ((rise_i[p] & went_up) | (fall_i[p] & went_down))
                              : level_hit;
  end
endmodule

// File: rtl/wpm_regbank.sv
module wpm_regbank
  import wpm_pkg::*;
#(
  parameter int PIN_COUNT = 64,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [WORD_W-1:0]    bus_wdata_i,
  output logic [WORD_W-1:0]    bus_rdata_o,
  input  logic [PIN_COUNT-1:0] event_i,
  output logic [PIN_COUNT-1:0] en_o,
  output logic [PIN_COUNT-1:0] fall_o,
  output logic [PIN_COUNT-1:0] rise_o,
  output logic [PIN_COUNT-1:0] pol_o,
  output logic [PIN_COUNT-1:0] stat_o
);
  localparam int STRIDE  = stride_of(PIN_COUNT);
  localparam int PADW    = STRIDE * WORD_W;
  localparam int CFG_CNT = BANK_CNT - 1;

  logic [WORD_W-1:0] widx;
  logic [WORD_W-1:0] timer_q [TIMER_CNT];
  logic [WORD_W-1:0] timer_d [TIMER_CNT];
  logic [PADW-1:0]   cfg_q   [CFG_CNT];
  logic [PADW-1:0]   cfg_d   [CFG_CNT];
  logic [PADW-1:0]   stat_q;
  logic [PADW-1:0]   stat_d;
  logic [PADW-1:0]   keep_mask;
  logic [PADW-1:0]   event_pad;

  assign widx      = WORD_W'(bus_addr_i[ADDR_W-1:2]);
  assign event_pad = PADW'(event_i);

  // next-state: decoded writes, status clear-by-zero, event set wins
  always_comb begin
    timer_d   = timer_q;
    cfg_d     = cfg_q;
    keep_mask = '1;
    if (bus_we_i) begin
      for (int t = 0; t < TIMER_CNT; t++) begin
        if (widx == WORD_W'(t)) timer_d[t] = bus_wdata_i;
      end
      for (int k = 0; k < CFG_CNT; k++) begin
        for (int i = 0; i < STRIDE; i++) begin
          if (widx == WORD_W'(word_index(k, i, STRIDE))) cfg_d[k][i*WORD_W +: WORD_W] = bus_wdata_i;
        end
      end
      for (int i = 0; i < STRIDE; i++) begin
        if (widx == WORD_W'(word_index(BK_STATUS, i, STRIDE))) keep_mask[i*WORD_W +: WORD_W] = bus_wdata_i;
      end
    end
    stat_d = (stat_q & keep_mask) | event_pad;
    for (int b = PIN_COUNT; b < PADW; b++) begin
      stat_d[b] = 1'b0;
      for (int k = 0; k < CFG_CNT; k++) cfg_d[k][b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '{default: '0};
      cfg_q   <= '{default: '0};
    end else if (bus_we_i) begin
      timer_q <= timer_d;
      cfg_q   <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  // read path: unmatched addresses fall through to zero
  always_comb begin
    bus_rdata_o = '0;
    for (int t = 0; t < TIMER_CNT; t++) begin
      if (widx == WORD_W'(t)) bus_rdata_o = timer_q[t];
    end
    for (int k = 0; k < CFG_CNT; k++) begin
      for (int i = 0; i < STRIDE; i++) begin
        if (widx == WORD_W'(word_index(k, i, STRIDE))) bus_rdata_o = cfg_q[k][i*WORD_W +: WORD_W];
      end
    end
    for (int i = 0; i < STRIDE; i++) begin
      if (widx == WORD_W'(word_index(BK_STATUS, i, STRIDE))) bus_rdata_o = stat_q[i*WORD_W +: WORD_W];
    end
  end

  assign en_o   = cfg_q[BK_ENABLE][PIN_COUNT-1:0];
  assign fall_o = cfg_q[BK_FALL][PIN_COUNT-1:0];
  assign rise_o = cfg_q[BK_RISE][PIN_COUNT-1:0];
  assign pol_o  = cfg_q[BK_POL][PIN_COUNT-1:0];
  assign stat_o = stat_q[PIN_COUNT-1:0];
endmodule

// File: rtl/wake_pin_monitor.sv
module wake_pin_monitor #(
  parameter int PIN_COUNT = 64,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] wake_pins_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 wake_irq_o
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic [PIN_COUNT-1:0] sync_w;
  logic [PIN_COUNT-1:0] event_w;
  logic [PIN_COUNT-1:0] en_w;
  logic [PIN_COUNT-1:0] fall_w;
  logic [PIN_COUNT-1:0] rise_w;
  logic [PIN_COUNT-1:0] pol_w;
  logic [PIN_COUNT-1:0] stat_w;
  logic                 wake_d;
  logic                 wake_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  wpm_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (wake_pins_i),
    .sync_o  (sync_w)
  );

  wpm_detect #(.PIN_COUNT(PIN_COUNT)) u_detect (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sync_i  (sync_w),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .pol_i   (pol_w),
    .event_o (event_w)
  );

  wpm_regbank #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .event_i     (event_w),
    .en_o        (en_w),
    .fall_o      (fall_w),
    .rise_o      (rise_w),
    .pol_o       (pol_w),
    .stat_o      (stat_w)
  );

  assign wake_d = |(stat_w & en_w);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
    end
  end

  assign wake_irq_o = wake_q;
endmodule

// File: rtl/wpm_checker.sv
module wpm_checker #(
  parameter int PIN_COUNT = 64,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [31:0]          bus_rdata_o,
  input logic [PIN_COUNT-1:0] en,
  input logic [PIN_COUNT-1:0] stat,
  input logic                 wake
);
  localparam int STRIDE = (PIN_COUNT + 31) / 32;
  localparam int NWORDS = 2 + 5 * STRIDE;

  logic [31:0] widx;
  assign widx = 32'(bus_addr_i[ADDR_W-1:2]);

  AST_WAKE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(|(stat & en)));  // R6

  AST_WAKE_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en)) |=> wake);  // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_i |=> (($past(stat) & ~stat) == '0));  // R11

  AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_i |=> $stable(en));  // R3

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (widx >= 32'(NWORDS)) |-> (bus_rdata_o == '0));  // R10
endmodule

bind wake_pin_monitor wpm_checker #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .en          (en_w),
  .stat        (stat_w),
  .wake        (wake_irq_o)
);

// File: tb/test_wake_pin_monitor.sv
module test_wake_pin_monitor;
  localparam int PINS   = 64;
  localparam int AW     = 8;
  localparam int STRIDE = (PINS + 31) / 32;
  localparam int NWORDS = 2 + 5 * STRIDE;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PINS-1:0] pins;
  logic            we;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic            wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  wake_pin_monitor #(.PIN_COUNT(PINS), .ADDR_W(AW)) i_wake_pin_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_pins_i (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .wake_irq_o  (wake)
  );

  function automatic logic [AW-1:0] ra(input int bank, input int sub);
    return AW'((bank * STRIDE + sub + 2) * 4);
  endfunction

  function automatic logic [63:0] exp_stat(input logic [63:0] r, input logic [63:0] f,
                                           input logic [63:0] p, input logic [63:0] o,
                                           input logic [63:0] n);
    logic [63:0] e;
    for (int b = 0; b < 64; b++) begin
      if (r[b] | f[b]) e[b] = (r[b] & ~o[b] & n[b]) | (f[b] & o[b] & ~n[b]);
      else             e[b] = (o[b] == p[b]) | (n[b] == p[b]);
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr64(input int bank, input logic [63:0] v);
    wr(ra(bank, 0), v[31:0]);
    wr(ra(bank, 1), v[63:32]);
  endtask

  task automatic rd64(input int bank, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(ra(bank, 0), lo);
    rd(ra(bank, 1), hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, r, f, p, e, o, n, en;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    cyc(3);
    // R2: all words zero while reset is held
    for (int w = 0; w < NWORDS; w++) begin
      rd(AW'(w * 4), d);
      chk($sformatf("R2 reset word %0d", w), 64'(d), 64'd0);
    end
    chk("R2 wake in reset", 64'(wake), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    cyc(6);
    for (int w = 0; w < 2 + 4 * STRIDE; w++) begin
      rd(AW'(w * 4), d);
      chk($sformatf("R2 after release word %0d", w), 64'(d), 64'd0);
    end

    // R3: read back of plain storage and configuration words
    for (int w = 0; w < 2 + 4 * STRIDE; w++) begin
      logic [31:0] val;
      val = $urandom;
      wr(AW'(w * 4), val);
      rd(AW'(w * 4), d);
      chk($sformatf("R3 readback word %0d", w), 64'(d), 64'(val));
    end

    // R4 R5 R6 R7 R11: randomized trials
    for (int t = 0; t < 40; t++) begin
      r  = {$urandom, $urandom} & {$urandom, $urandom};
      f  = {$urandom, $urandom} & {$urandom, $urandom};
      p  = {$urandom, $urandom};
      en = {$urandom, $urandom};
      o  = {$urandom, $urandom};
      n  = o ^ {$urandom, $urandom};
      wr64(0, en); wr64(1, f); wr64(2, r); wr64(3, p);
      @(negedge clk); pins = o;
      cyc(5);
      wr64(4, 64'd0);
      cyc(2);
      pins = n;
      cyc(6);
      e = exp_stat(r, f, p, o, n);
      rd64(4, v);
      chk($sformatf("R4 R5 R11 status trial %0d", t), v, e);
      chk($sformatf("R6 R7 wake trial %0d", t), 64'(wake), 64'(|(e & en)));
    end

    // directed set-up: pins low, active-high levels, a few rising pins
    @(negedge clk); pins = '0;
    wr64(0, 64'h0000_0000_0000_0020);
    wr64(1, 64'd0);
    wr64(2, 64'h0000_0100_0000_00A8);
    wr64(3, {64{1'b1}});
    cyc(5);
    wr64(4, 64'd0);
    cyc(2);
    rd64(4, v);
    chk("R5 quiet pins", v, 64'd0);

    // R9: latency on pin 5 (rising, enabled)
    rd(ra(4, 0), d);
    pins[5] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 status after 2 edges", 64'(rdata), 64'd0);
    @(posedge clk); #1;
    chk("R9 status after 3 edges", 64'(rdata), 64'h20);
    chk("R9 wake after 3 edges", 64'(wake), 64'd0);
    @(posedge clk); #1;
    chk("R9 wake after 4 edges", 64'(wake), 64'd1);

    // R7: disable drops wake one clock after the write
    wr(ra(0, 0), 32'd0);
    chk("R7 wake still registered", 64'(wake), 64'd1);
    @(posedge clk); #1;
    chk("R7 wake after disable", 64'(wake), 64'd0);
    wr(ra(0, 0), 32'h20);
    cyc(2);
    chk("R7 wake re-enabled", 64'(wake), 64'd1);
    cyc(4);
    chk("R7 R11 wake held", 64'(wake), 64'd1);
    wr(ra(4, 0), 32'd0);
    @(posedge clk); #1;
    chk("R7 wake after clear", 64'(wake), 64'd0);

    // R6: disabled level pin latches but does not wake
    @(negedge clk); pins[10] = 1'b1;
    cyc(5);
    rd(ra(4, 0), d);
    chk("R6 disabled status", 64'(d), 64'h400);
    chk("R6 disabled wake", 64'(wake), 64'd0);
    // R8: event in the clear cycle wins
    wr(ra(4, 0), 32'd0);
    rd(ra(4, 0), d);
    chk("R8 clear loses to live level", 64'(d), 64'h400);
    // R11: sticky after condition goes away
    @(negedge clk); pins[10] = 1'b0;
    cyc(5);
    wr(ra(4, 0), 32'hFFFF_FFFF);
    rd(ra(4, 0), d);
    chk("R11 sticky after pin drop", 64'(d), 64'h400);
    wr(ra(4, 0), 32'd0);
    rd(ra(4, 0), d);
    chk("R8 clear", 64'(d), 64'd0);

    // R8: one bits keep, zero bits clear
    @(negedge clk); pins[3] = 1'b1; pins[7] = 1'b1;
    cyc(5);
    rd(ra(4, 0), d);
    chk("R4 two rising pins", 64'(d), 64'h88);
    wr(ra(4, 0), 32'hFFFF_FF7F);
    rd(ra(4, 0), d);
    chk("R8 selective clear", 64'(d), 64'h08);

    // R1: pin 40 lands in status word 1 bit 8 at 0x2C
    @(negedge clk); pins[40] = 1'b1;
    cyc(5);
    rd(8'h2C, d);
    chk("R1 pin 40 status word", 64'(d), 64'h100);
    chk("R1 pin 40 not enabled", 64'(wake), 64'd0);
    wr(8'h0C, 32'h100);
    cyc(2);
    chk("R1 pin 40 enable word", 64'(wake), 64'd1);

    // R10: out-of-range addresses
    rd(ra(2, 0), d);
    wr(AW'(NWORDS * 4), 32'hDEAD_BEEF);
    wr(8'hFC, 32'h1234_5678);
    rd(AW'(NWORDS * 4), v[31:0]);
    chk("R10 read past end", 64'(v[31:0]), 64'd0);
    rd(8'hFC, v[31:0]);
    chk("R10 read top address", 64'(v[31:0]), 64'd0);
    rd(ra(2, 0), v[31:0]);
    chk("R10 rising word untouched", 64'(v[31:0]), 64'(d));
    rd(8'h0C, v[31:0]);
    chk("R10 enable word untouched", 64'(v[31:0]), 64'h100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule